// File: doc/BRIEF.md
# FIFO Threshold Offset Loader

This block keeps the two threshold offsets that a FIFO's flag logic compares against the fill level. One offset sets the almost-empty distance and the other sets the almost-full distance. It contains no FIFO storage. It only holds the two offsets, loads them, and presents them to the flag logic.

The level of the load pin during master reset fixes two things. The first is the value both offsets start from. The second is the loading method that applies until the next master reset. In word mode the offsets are written one data-bus-wide word at a time. An offset wider than the bus takes several words, and a word pointer steps through them. In bit mode the offsets are shifted in one bit at a time from a serial input. In both modes the offsets can be read back as words on the read data bus, under a separate pointer.

A partial reset returns both word pointers to the first word. It does not change the offsets, the mode or the serial bit count. Master reset (rst_ni low) must span at least one write-clock edge, because the mode and the default offsets are sampled on that edge.

Top module: `flo_loader`

## Requirements
- R1: If load_i is high on a write-clock edge while rst_ni is low, both offsets become 127 and par_mode_o is 1 (word mode).
- R2: If load_i is low on a write-clock edge while rst_ni is low, both offsets become 1023 and par_mode_o is 0 (bit mode).
- R3: In word mode, an edge with wen_i and load_i high writes d_i into the word that wsel_o selects. The words are: word 0 is almost-empty bits 8:0, word 1 is almost-empty bits 16:9 (d_i bit 8 dropped), word 2 is almost-full bits 8:0, and word 3 is almost-full bits 16:9.
- R4: Each word-mode write advances wsel_o by one, and wsel_o wraps from 3 back to 0.
- R5: In bit mode, an edge with sen_i and load_i high stores si_i in the next bit position. Positions 0 to 16 fill almost-empty bit 0 up to bit 16. Positions 17 to 33 then fill almost-full bit 0 up to bit 16.
- R6: After 34 bits have been stored, further bit-mode loads leave both offsets unchanged until the next master reset, including across partial resets.
- R7: wen_i has no effect on the offsets in bit mode, and sen_i has no effect on them in word mode.
- R8: A read-clock edge with ren_i and load_i high puts the word that rsel_o selects onto q_o, registered, using the word numbering of R3. rsel_o then advances with wrap from 3 to 0. This works in both modes.
- R9: q_o holds its value on every read-clock edge that is not a readback edge.
- R10: An edge with part_rst_ni low clears wsel_o and rsel_o to 0 and performs no load and no readback. It leaves the offsets, the mode and the serial bit count unchanged.
- R11: With load_i low, wen_i and sen_i leave both offsets unchanged.
- R12: par_mode_o does not change between master resets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock; all loads happen on its rising edge |
| rclk_i | input | 1 | Read clock; readback happens on its rising edge |
| rst_ni | input | 1 | Master reset, active low |
| part_rst_ni | input | 1 | Partial reset, active low, sampled on the clock edge |
| load_i | input | 1 | Offset access qualifier; also selects the mode during master reset |
| wen_i | input | 1 | Word-mode write enable |
| sen_i | input | 1 | Bit-mode shift enable |
| si_i | input | 1 | Serial offset bit |
| d_i | input | DW | Write data word |
| ren_i | input | 1 | Readback enable |
| q_o | output | DW | Readback word |
| ae_off_o | output | OW | Almost-empty offset |
| af_off_o | output | OW | Almost-full offset |
| par_mode_o | output | 1 | 1 for word mode, 0 for bit mode |
| wsel_o | output | log2(2*ceil(OW/DW)) | Word pointer for writes |
| rsel_o | output | log2(2*ceil(OW/DW)) | Word pointer for readback |

## Verification
The assertions assume that both clocks are the same net and that partial reset is sampled synchronously. Under that assumption, the offsets that readback sees on a read edge are exactly the ones written before that edge. They also assume that load_i stays constant through each master reset, so the sampled mode is well defined. The stimulus drives one shared 100 MHz clock into both clock ports, changes every input only on the falling edge, and holds load_i steady for the whole time rst_ni is low.

// File: rtl/flo_pkg.sv
package flo_pkg;
  typedef enum logic {
    MODE_SER = 1'b0,
    MODE_PAR = 1'b1
  } load_mode_e;

  function automatic int words_per_off(input int ow, input int dw);
    return (ow + dw - 1) / dw;
  endfunction
endpackage

// File: rtl/flo_word_ptr.sv
module flo_word_ptr #(
  parameter int N = 4,
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         adv_i,
  output logic [W-1:0] ptr_o
);
  logic [W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               ptr_q <= '0;
    else if (clr_i)            ptr_q <= '0;
    else if (adv_i) begin
      if (ptr_q == W'(N - 1))  ptr_q <= '0;
      else                     ptr_q <= ptr_q + W'(1);
    end
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/flo_bit_cnt.sv
module flo_bit_cnt #(
  parameter int LIMIT = 34,
  parameter int W     = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o,
  output logic         room_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + W'(1);
  end

  assign cnt_o  = cnt_q;
  assign room_o = (cnt_q < W'(LIMIT));
endmodule

// File: rtl/flo_regs.sv
module flo_regs
  import flo_pkg::*;
#(
  parameter int DW      = 9,
  parameter int OW      = 17,
  parameter int NWORD   = 4,
  parameter int PTRW    = 2,
  parameter int CW      = 6,
  parameter int DEF_PAR = 127,
  parameter int DEF_SER = 1023
) (
  input  logic            wclk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic            par_we_i,
  input  logic [PTRW-1:0] par_idx_i,
  input  logic [DW-1:0]   par_data_i,
  input  logic            ser_we_i,
  input  logic [CW-1:0]   ser_idx_i,
  input  logic            ser_bit_i,
  output logic            par_mode_o,
  output logic [OW-1:0]   ae_o,
  output logic [OW-1:0]   af_o
);
  localparam int PW = (NWORD / 2) * DW;

  load_mode_e        mode_q;
  logic [2*OW-1:0]   cat_q, cat_ser;
  logic [2*PW-1:0]   pad, pad_n;

  always_comb begin
    pad   = {PW'(cat_q[2*OW-1:OW]), PW'(cat_q[OW-1:0])};
    pad_n = pad;
    for (int k = 0; k < NWORD; k++)
      if (par_idx_i == PTRW'(k)) pad_n[k*DW +: DW] = par_data_i;
    cat_ser = cat_q;
    for (int i = 0; i < 2*OW; i++)
      if (ser_idx_i == CW'(i)) cat_ser[i] = ser_bit_i;
  end

  // mode and defaults are sampled on write-clock edges while master reset is low
  always_ff @(posedge wclk_i) begin
    if (!rst_ni) begin
      mode_q <= load_i ? MODE_PAR : MODE_SER;
      cat_q  <= load_i ? {2{OW'(DEF_PAR)}} : {2{OW'(DEF_SER)}};
    end else if (par_we_i) begin
      cat_q  <= {pad_n[PW +: OW], pad_n[OW-1:0]};
    end else if (ser_we_i) begin
      cat_q  <= cat_ser;
    end
  end

  assign par_mode_o = (mode_q == MODE_PAR);
  assign ae_o       = cat_q[OW-1:0];
  assign af_o       = cat_q[2*OW-1:OW];
endmodule

// File: rtl/flo_loader.sv
module flo_loader
  import flo_pkg::*;
#(
  parameter int DW      = 9,
  parameter int OW      = 17,
  parameter int DEF_PAR = 127,
  parameter int DEF_SER = 1023,
  localparam int NWORD  = 2 * words_per_off(OW, DW),
  localparam int PTRW   = $clog2(NWORD)
) (
  input  logic            wclk_i,
  input  logic            rclk_i,
  input  logic            rst_ni,
  input  logic            part_rst_ni,
  input  logic            load_i,
  input  logic            wen_i,
  input  logic            sen_i,
  input  logic            si_i,
  input  logic [DW-1:0]   d_i,
  input  logic            ren_i,
  output logic [DW-1:0]   q_o,
  output logic [OW-1:0]   ae_off_o,
  output logic [OW-1:0]   af_off_o,
  output logic            par_mode_o,
  output logic [PTRW-1:0] wsel_o,
  output logic [PTRW-1:0] rsel_o
);
  localparam int PW    = (NWORD / 2) * DW;
  localparam int NBITS = 2 * OW;
  localparam int CW    = $clog2(NBITS + 1);

  logic            par_mode, ser_room, par_we, ser_we, rd_en;
  logic [CW-1:0]   ser_idx;
  logic [OW-1:0]   ae_off, af_off;
  logic [PTRW-1:0] wsel, rsel;
  logic [2*PW-1:0] rd_pad;
  logic [DW-1:0]   rd_word, q_q;

  assign par_we = part_rst_ni & load_i & wen_i & par_mode;
  assign ser_we = part_rst_ni & load_i & sen_i & ~par_mode & ser_room;
  assign rd_en  = part_rst_ni & load_i & ren_i;

  flo_word_ptr #(.N(NWORD), .W(PTRW)) u_wptr (
    .clk_i(wclk_i), .rst_ni(rst_ni), .clr_i(~part_rst_ni),
    .adv_i(par_we), .ptr_o(wsel)
  );

  flo_word_ptr #(.N(NWORD), .W(PTRW)) u_rptr (
    .clk_i(rclk_i), .rst_ni(rst_ni), .clr_i(~part_rst_ni),
    .adv_i(rd_en), .ptr_o(rsel)
  );

  flo_bit_cnt #(.LIMIT(NBITS), .W(CW)) u_bcnt (
    .clk_i(wclk_i), .rst_ni(rst_ni), .inc_i(ser_we),
    .cnt_o(ser_idx), .room_o(ser_room)
  );

  flo_regs #(
    .DW(DW), .OW(OW), .NWORD(NWORD), .PTRW(PTRW), .CW(CW),
    .DEF_PAR(DEF_PAR), .DEF_SER(DEF_SER)
  ) u_regs (
    .wclk_i(wclk_i), .rst_ni(rst_ni), .load_i(load_i),
    .par_we_i(par_we), .par_idx_i(wsel), .par_data_i(d_i),
    .ser_we_i(ser_we), .ser_idx_i(ser_idx), .ser_bit_i(si_i),
    .par_mode_o(par_mode), .ae_o(ae_off), .af_o(af_off)
  );

  always_comb begin
    rd_pad  = {PW'(af_off), PW'(ae_off)};
    rd_word = '0;
    for (int k = 0; k < NWORD; k++)
      if (rsel == PTRW'(k)) rd_word = rd_pad[k*DW +: DW];
  end

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni)    q_q <= '0;
    else if (rd_en) q_q <= rd_word;
  end

  assign q_o        = q_q;
  assign ae_off_o   = ae_off;
  assign af_off_o   = af_off;
  assign par_mode_o = par_mode;
  assign wsel_o     = wsel;
  assign rsel_o     = rsel;
endmodule

// File: rtl/flo_loader_chk.sv
module flo_loader_chk #(
  parameter int DW   = 9,
  parameter int OW   = 17,
  parameter int PTRW = 2,
  parameter int NWORD = 4
) (
  input logic            wclk_i,
  input logic            rclk_i,
  input logic            rst_ni,
  input logic            part_rst_ni,
  input logic            load_i,
  input logic            wen_i,
  input logic            sen_i,
  input logic            ren_i,
  input logic [DW-1:0]   q_o,
  input logic [OW-1:0]   ae_off_o,
  input logic [OW-1:0]   af_off_o,
  input logic            par_mode_o,
  input logic [PTRW-1:0] wsel_o,
  input logic [PTRW-1:0] rsel_o
);
  p_wsel_step_r4: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (part_rst_ni && load_i && wen_i && par_mode_o) |=>
      (wsel_o == (($past(wsel_o) == PTRW'(NWORD - 1)) ? '0 : $past(wsel_o) + PTRW'(1))));

  p_rsel_step_r8: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (part_rst_ni && load_i && ren_i) |=>
      (rsel_o == (($past(rsel_o) == PTRW'(NWORD - 1)) ? '0 : $past(rsel_o) + PTRW'(1))));

  p_q_hold_r9: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    !(part_rst_ni && load_i && ren_i) |=> $stable(q_o));

  p_partial_keep_r10: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    !part_rst_ni |=> (wsel_o == '0) && $stable(ae_off_o) && $stable(af_off_o));

  p_partial_rsel_r10: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    !part_rst_ni |=> (rsel_o == '0));

  p_idle_keep_r11: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    !load_i |=> $stable(ae_off_o) && $stable(af_off_o));

  p_ser_no_wsel_r7: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (!par_mode_o && part_rst_ni) |=> $stable(wsel_o));

  p_mode_par_fixed_r12: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    par_mode_o |=> par_mode_o);

  p_mode_ser_fixed_r12: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    !par_mode_o |=> !par_mode_o);
endmodule

bind flo_loader flo_loader_chk #(.DW(DW), .OW(OW), .PTRW(PTRW), .NWORD(NWORD)) u_chk (
  .wclk_i(wclk_i), .rclk_i(rclk_i), .rst_ni(rst_ni), .part_rst_ni(part_rst_ni),
  .load_i(load_i), .wen_i(wen_i), .sen_i(sen_i), .ren_i(ren_i),
  .q_o(q_o), .ae_off_o(ae_off_o), .af_off_o(af_off_o), .par_mode_o(par_mode_o),
  .wsel_o(wsel_o), .rsel_o(rsel_o)
);

// File: tb/flo_loader_test.sv
`timescale 1ns/1ps
module flo_loader_test;
  localparam int DW = 9;
  localparam int OW = 17;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_ni = 1'b0, part_rst_ni = 1'b1, load = 1'b0;
  logic          wen = 1'b0, sen = 1'b0, si = 1'b0, ren = 1'b0;
  logic [DW-1:0] d = '0;
  logic [DW-1:0] q;
  logic [OW-1:0] ae, af;
  logic          pm;
  logic [1:0]    wsel, rsel;

  flo_loader uut (
    .wclk_i(clk), .rclk_i(clk), .rst_ni(rst_ni), .part_rst_ni(part_rst_ni),
    .load_i(load), .wen_i(wen), .sen_i(sen), .si_i(si), .d_i(d), .ren_i(ren),
    .q_o(q), .ae_off_o(ae), .af_off_o(af), .par_mode_o(pm),
    .wsel_o(wsel), .rsel_o(rsel)
  );

  int nvec = 0, nbad = 0;
  int m_ae, m_af, m_ws, m_rs, m_cnt, m_q, m_pm;

  function automatic int word_of(input int k);
    int v;
    v = (k < 2) ? m_ae : m_af;
    return (k % 2 == 0) ? (v & 'h1FF) : ((v >> 9) & 'h1FF);
  endfunction

  task automatic check(input string tag);
    nvec++;
    if (int'(q) != m_q || int'(ae) != m_ae || int'(af) != m_af || int'(pm) != m_pm ||
        int'(wsel) != m_ws || int'(rsel) != m_rs) begin
      nbad++;
      $display("FAIL %s: q=%0h ae=%0h af=%0h pm=%0d ws=%0d rs=%0d | exp q=%0h ae=%0h af=%0h pm=%0d ws=%0d rs=%0d",
               tag, q, ae, af, pm, wsel, rsel, m_q, m_ae, m_af, m_pm, m_ws, m_rs);
    end
  endtask

  task automatic mreset(input bit ld, input string tag);
    @(negedge clk);
    rst_ni = 1'b0; load = ld; wen = 0; sen = 0; ren = 0; part_rst_ni = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    m_ae = ld ? 127 : 1023; m_af = m_ae; m_pm = ld;
    m_ws = 0; m_rs = 0; m_cnt = 0; m_q = 0;
    #1 check(tag);
  endtask

  task automatic cyc(input bit w, input bit s, input bit r, input bit l, input bit p,
                     input int dv, input bit b, input string tag);
    int v;
    @(negedge clk);
    wen = w; sen = s; ren = r; load = l; part_rst_ni = p; d = DW'(dv); si = b;
    if (!p) begin
      m_ws = 0; m_rs = 0;
    end else begin
      if (r && l) begin
        m_q  = word_of(m_rs);
        m_rs = (m_rs + 1) % 4;
      end
      if (w && l && m_pm == 1) begin
        v = (m_ws < 2) ? m_ae : m_af;
        if (m_ws % 2 == 0) v = (v & ~'h1FF) | (dv & 'h1FF);
        else               v = (v & 'h1FF) | ((dv & 'hFF) << 9);
        if (m_ws < 2) m_ae = v; else m_af = v;
        m_ws = (m_ws + 1) % 4;
      end
      if (s && l && m_pm == 0 && m_cnt < 34) begin
        if (m_cnt < 17) m_ae = b ? (m_ae | (1 << m_cnt)) : (m_ae & ~(1 << m_cnt));
        else            m_af = b ? (m_af | (1 << (m_cnt - 17))) : (m_af & ~(1 << (m_cnt - 17)));
        m_cnt++;
      end
    end
    @(posedge clk);
    #1 check(tag);
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  endtask

  initial begin
    #200000;
    nbad++;
    $display("FAIL watchdog: run did not complete");
    summary();
  end

  initial begin
    int ae_pat, af_pat;
    ae_pat = 'h15A3C; af_pat = 'h0F0F1;

    // word mode
    mreset(1'b1, "R1");
    cyc(0,0,0,0,1, 0, 0, "R1");
    cyc(1,0,0,1,1, 'h1F3, 0, "R3");
    cyc(1,0,0,1,1, 'h1AB, 0, "R3");
    cyc(1,0,0,1,1, 'h055, 0, "R3");
    cyc(1,0,0,1,1, 'h1CC, 0, "R4");
    cyc(1,0,0,1,1, 'h077, 0, "R4");
    for (int i = 0; i < 5; i++) cyc(0,0,1,1,1, 0, 0, "R8");
    cyc(0,0,0,1,1, 0, 0, "R9");
    cyc(0,0,1,0,1, 0, 0, "R9");
    cyc(1,0,0,0,1, 'h1FF, 0, "R11");
    cyc(0,1,0,1,1, 0, 1, "R7");
    cyc(0,1,0,1,1, 0, 0, "R7");
    cyc(1,0,1,1,0, 'h0AA, 0, "R10");
    cyc(0,0,1,1,1, 0, 0, "R10");
    cyc(1,0,1,1,1, 'h123, 0, "R8");
    cyc(0,0,0,0,1, 0, 0, "R12");

    // bit mode
    mreset(1'b0, "R2");
    cyc(0,0,1,1,1, 0, 0, "R8");
    cyc(0,0,1,1,1, 0, 0, "R8");
    for (int i = 0; i < 17; i++) cyc(0,1,0,1,1, 0, (ae_pat >> i) & 1, "R5");
    cyc(0,1,0,0,1, 0, 1, "R11");
    cyc(0,1,0,1,0, 0, 1, "R10");
    for (int i = 0; i < 17; i++) cyc(0,1,0,1,1, 0, (af_pat >> i) & 1, "R5");
    for (int i = 0; i < 4; i++)  cyc(0,1,0,1,1, 0, i & 1 ? 0 : 1, "R6");
    cyc(1,0,0,1,1, 'h1FF, 0, "R7");
    cyc(0,0,0,1,0, 0, 0, "R10");
    cyc(0,1,0,1,1, 0, 0, "R6");
    cyc(0,1,0,1,1, 0, 1, "R6");
    for (int i = 0; i < 5; i++) cyc(0,0,1,1,1, 0, 0, "R8");
    cyc(0,0,0,1,1, 0, 0, "R12");

    // mixed traffic in both modes
    for (int m = 0; m < 2; m++) begin
      mreset(m == 0, m == 0 ? "R1" : "R2");
      for (int i = 0; i < 200; i++)
        cyc($urandom_range(0,1), $urandom_range(0,1), $urandom_range(0,1),
            $urandom_range(0,3) != 0, $urandom_range(0,9) != 0,
            int'($urandom_range(0, 511)), $urandom_range(0,1), "R12");
    end
    summary();
  end
endmodule